// File: doc/BRIEF.md
# Watchdog Timer with Keyed External Reset Pulse

This block is a watchdog timer on a plain 32-bit register bus with word-aligned byte offsets. Software loads a reload value and enables counting. It then has to write a fixed key to the restart register at regular intervals, and each such write reloads the down-counter. The counter advances on a tick that is either every system clock or a slower tick made by a prescaler. When it runs out, the block reloads itself. It can raise a one-cycle interrupt request, a one-cycle system reset request with a full-chip qualifier, and an external reset pulse of programmable length.

The external pulse is shaped by a reset-width register. Its low twelve bits set the pulse length, counted in ticks of the selected clock. Its two top bits choose the active level and whether the pin driver is push-pull or open-drain. Those two bits cannot be written directly. They change only when one of four key bytes appears in the top byte of a write, which protects the pin configuration against stray writes. The block drives a pin level and a pin output enable, and an external pad consumes them.

Top module: `wdog_keyed_pulse`

## Requirements
- R1: Byte offsets decode as: 0x00 status (reads the live counter value), 0x04 reload value, 0x08 restart (reads 0), 0x0C control (bits 5:0), 0x18 reset width. Any other offset, and any address with bits 1:0 not zero, reads 0 and writes nothing.
- R2: After reset the status and reload registers both read 0x03EF1480, control reads 0, reset width reads 0x000000FF, the pin sits at its inactive level (high) and the output enable is 0.
- R3: Writing exactly 0x00004755 to the restart register loads the counter from the reload value at that clock edge. Any other data leaves the counter unchanged.
- R4: With control bit 0 set, each tick decrements a nonzero counter. A tick with the counter at zero is a timeout, and the counter reloads. With bit 0 clear, the counter holds. After a restart with reload value N and a tick every cycle, the timeout occurs at the (N+1)th tick.
- R5: With control bit 4 clear, a tick occurs every clock. With it set, a tick occurs once every PRESCALE clocks.
- R6: On a timeout, timeout_irq pulses for one cycle if control bit 2 is set. sys_rst_req pulses for one cycle if control bit 1 is set, and sys_rst_full then equals control bit 5. Both appear in the cycle after the timeout edge.
- R7: On a timeout with control bit 3 set, the external pulse becomes active for (duration + 1) ticks. With bit 3 clear, no pulse starts.
- R8: In a reset-width write, top byte 0xA5 sets bit 31 (active high) and top byte 0x5A clears it.
- R9: In a reset-width write, top byte 0xA8 sets bit 30 (push-pull) and top byte 0x8A clears it. Any other top byte leaves bits 31 and 30 unchanged.
- R10: Every reset-width write copies data bits 11:0 into the duration field, whatever its top byte. Bits 29:12 always read 0.
- R11: ext_rst_o equals bit 31 while the pulse is active, and equals the inverse of bit 31 otherwise.
- R12: With bit 30 clear, ext_rst_oe is 1 only while the pulse is active. With bit 30 set, ext_rst_oe is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| timeout_irq | output | 1 | One-cycle interrupt request on timeout |
| sys_rst_req | output | 1 | One-cycle system reset request on timeout |
| sys_rst_full | output | 1 | Full-chip qualifier for sys_rst_req |
| ext_rst_o | output | 1 | External reset pin level |
| ext_rst_oe | output | 1 | External reset pin output enable |

## Verification
The bench counts cycles from a restart to the first active pulse cycle. An off-by-one in reload or expiry, or a restart that loses to a same-cycle tick, moves that edge by one cycle. It measures pulse length in both tick modes, which catches a pulse that counts clocks instead of ticks or that stops one tick early. A long random run of reset-width writes, with the key bytes favoured, is compared against a model of the key decode: a design that lets plain writes touch the level or drive bits, or mixes up the two key pairs, ends up with a different read-back. Non-key restart data, disabled counting and a cleared pulse-enable bit are all checked at the ports for having no effect.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int DATA_W = 32;
    localparam int DUR_W  = 12;

    // word index (byte offset / 4) of each register
    localparam int IDX_STATUS  = 0;
    localparam int IDX_RELOAD  = 1;
    localparam int IDX_RESTART = 2;
    localparam int IDX_CTRL    = 3;
    localparam int IDX_WIDTH   = 6;

    localparam logic [DATA_W-1:0] RESTART_KEY    = 32'h0000_4755;
    localparam logic [DATA_W-1:0] RELOAD_DEFAULT = 32'h03EF_1480;

    localparam logic [7:0] KEY_LVL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_LVL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    // bit order matches control register bits 5..0
    typedef struct packed {
        logic full_chip;
        logic slow_tick;
        logic ext_en;
        logic irq_en;
        logic sys_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic             act_high;
        logic             push_pull;
        logic [DUR_W-1:0] dur;
    } width_t;

    localparam width_t WIDTH_DEFAULT = '{act_high: 1'b0, push_pull: 1'b0, dur: 12'h0FF};

    typedef enum logic [1:0] {
        KEY_NONE,
        KEY_SET,
        KEY_CLR
    } key_op_e;

    function automatic key_op_e level_key(input logic [7:0] top);
        if (top == KEY_LVL_HIGH)     return KEY_SET;
        else if (top == KEY_LVL_LOW) return KEY_CLR;
        else                         return KEY_NONE;
    endfunction

    function automatic key_op_e drive_key(input logic [7:0] top);
        if (top == KEY_DRV_PP)      return KEY_SET;
        else if (top == KEY_DRV_OD) return KEY_CLR;
        else                        return KEY_NONE;
    endfunction

    function automatic logic apply_key(input logic cur, input key_op_e op);
        case (op)
            KEY_SET: return 1'b1;
            KEY_CLR: return 1'b0;
            default: return cur;
        endcase
    endfunction

    function automatic width_t width_next(input width_t cur, input logic [DATA_W-1:0] d);
        width_t nxt;
        nxt.act_high  = apply_key(cur.act_high, level_key(d[31:24]));
        nxt.push_pull = apply_key(cur.push_pull, drive_key(d[31:24]));
        nxt.dur       = d[DUR_W-1:0];
        return nxt;
    endfunction

    function automatic logic [DATA_W-1:0] width_word(input width_t w);
        return {w.act_high, w.push_pull, {(DATA_W-2-DUR_W){1'b0}}, w.dur};
    endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [COUNT_W-1:0] count,
    output logic [DATA_W-1:0]  bus_rdata,
    output ctrl_t              ctrl_q,
    output width_t             width_q,
    output logic [COUNT_W-1:0] reload_q,
    output logic               restart_hit
);

    localparam int IDX_W = ADDR_W - 2;

    logic              aligned;
    logic [IDX_W-1:0]  idx;
    logic              wr_hit;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr_hit  = bus_sel && bus_we && aligned;

    assign restart_hit = wr_hit && (idx == IDX_W'(IDX_RESTART)) && (bus_wdata == RESTART_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= COUNT_W'(RELOAD_DEFAULT);
            ctrl_q   <= '0;
            width_q  <= WIDTH_DEFAULT;
        end else if (wr_hit) begin
            case (idx)
                IDX_W'(IDX_RELOAD): reload_q <= bus_wdata[COUNT_W-1:0];
                IDX_W'(IDX_CTRL):   ctrl_q   <= ctrl_t'(bus_wdata[5:0]);
                IDX_W'(IDX_WIDTH):  width_q  <= width_next(width_q, bus_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(IDX_STATUS): bus_rdata = DATA_W'(count);
                IDX_W'(IDX_RELOAD): bus_rdata = DATA_W'(reload_q);
                IDX_W'(IDX_CTRL):   bus_rdata = DATA_W'(ctrl_q);
                IDX_W'(IDX_WIDTH):  bus_rdata = width_word(width_q);
                default:            bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdk_ticker.sv
module wdk_ticker #(
    parameter int PRESCALE = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic tick
);

    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign tick = slow_sel ? (pre_q == PRE_LAST) : 1'b1;

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int COUNT_W = 32,
    parameter logic [COUNT_W-1:0] COUNT_RST = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic               restart,
    input  logic [COUNT_W-1:0] reload,
    output logic [COUNT_W-1:0] count,
    output logic               expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    // a restart in the same cycle wins over the tick
    assign expire  = run && tick && at_zero && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= COUNT_RST;
        end else if (restart) begin
            count <= reload;
        end else if (run && tick) begin
            if (at_zero) count <= reload;
            else         count <= count - COUNT_W'(1);
        end
    end

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fire,
    input  logic [DUR_W-1:0] dur,
    input  logic             act_high,
    input  logic             push_pull,
    output logic             active,
    output logic             pin,
    output logic             pin_oe
);

    logic [DUR_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (fire) begin
            active   <= 1'b1;
            remain_q <= dur;
        end else if (active && tick) begin
            if (remain_q == '0) active   <= 1'b0;
            else                remain_q <= remain_q - DUR_W'(1);
        end
    end

    assign pin    = active ? act_high : !act_high;
    assign pin_oe = push_pull || active;

endmodule

// File: rtl/wdog_keyed_pulse.sv
module wdog_keyed_pulse
    import wdk_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int COUNT_W  = 32,
    parameter int PRESCALE = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              timeout_irq,
    output logic              sys_rst_req,
    output logic              sys_rst_full,
    output logic              ext_rst_o,
    output logic              ext_rst_oe
);

    ctrl_t              ctrl_q;
    width_t             width_q;
    logic [COUNT_W-1:0] reload_q;
    logic [COUNT_W-1:0] count;
    logic               restart_hit;
    logic               tick;
    logic               expire;
    logic               pulse_active;

    wdk_regs #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .count       (count),
        .bus_rdata   (bus_rdata),
        .ctrl_q      (ctrl_q),
        .width_q     (width_q),
        .reload_q    (reload_q),
        .restart_hit (restart_hit)
    );

    wdk_ticker #(.PRESCALE(PRESCALE)) u_ticker (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (ctrl_q.slow_tick),
        .tick     (tick)
    );

    wdk_counter #(.COUNT_W(COUNT_W), .COUNT_RST(COUNT_W'(RELOAD_DEFAULT))) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .tick    (tick),
        .restart (restart_hit),
        .reload  (reload_q),
        .count   (count),
        .expire  (expire)
    );

    wdk_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fire      (expire && ctrl_q.ext_en),
        .dur       (width_q.dur),
        .act_high  (width_q.act_high),
        .push_pull (width_q.push_pull),
        .active    (pulse_active),
        .pin       (ext_rst_o),
        .pin_oe    (ext_rst_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_irq  <= 1'b0;
            sys_rst_req  <= 1'b0;
            sys_rst_full <= 1'b0;
        end else begin
            timeout_irq  <= expire && ctrl_q.irq_en;
            sys_rst_req  <= expire && ctrl_q.sys_en;
            sys_rst_full <= expire && ctrl_q.sys_en && ctrl_q.full_chip;
        end
    end

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               timeout_irq,
    input logic               ext_rst_o,
    input logic               ext_rst_oe,
    input ctrl_t              ctrl_q,
    input width_t             width_q,
    input logic [COUNT_W-1:0] reload_q,
    input logic [COUNT_W-1:0] count,
    input logic               restart_hit,
    input logic               tick,
    input logic               pulse_active
);

    logic width_wr;
    logic [7:0] top;
    assign width_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(IDX_WIDTH * 4));
    assign top      = bus_wdata[31:24];

    assert_reset_width_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (width_q.dur == 12'h0FF && !width_q.act_high && !width_q.push_pull));

    assert_restart_load_R3: assert property (@(posedge clk) disable iff (rst)
        restart_hit |=> (count == $past(reload_q)));

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !restart_hit) |=> $stable(count));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && tick && !restart_hit && count != '0) |=> (count == $past(count) - COUNT_W'(1)));

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        timeout_irq |-> $past(ctrl_q.irq_en));

    assert_pulse_needs_ext_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_active) |-> $past(ctrl_q.ext_en));

    assert_level_key_R8: assert property (@(posedge clk) disable iff (rst)
        (width_wr && top == 8'hA5) |=> width_q.act_high);

    assert_plain_write_keeps_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (width_wr && top != 8'hA5 && top != 8'h5A && top != 8'hA8 && top != 8'h8A)
        |=> ($stable(width_q.act_high) && $stable(width_q.push_pull)));

    assert_od_level_R12: assert property (@(posedge clk) disable iff (rst)
        (ext_rst_oe && !width_q.push_pull) |-> (ext_rst_o == width_q.act_high));

endmodule

bind wdog_keyed_pulse wdk_checker #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_wdk_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .timeout_irq  (timeout_irq),
    .ext_rst_o    (ext_rst_o),
    .ext_rst_oe   (ext_rst_oe),
    .ctrl_q       (ctrl_q),
    .width_q      (width_q),
    .reload_q     (reload_q),
    .count        (count),
    .restart_hit  (restart_hit),
    .tick         (tick),
    .pulse_active (pulse_active)
);

// File: tb/tb_wdog_keyed_pulse.sv
`timescale 1ns/100ps
module tb_wdog_keyed_pulse;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timeout_irq, sys_rst_req, sys_rst_full, ext_rst_o, ext_rst_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wdog_keyed_pulse #(.ADDR_W(5), .COUNT_W(32), .PRESCALE(DIV)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timeout_irq(timeout_irq),
        .sys_rst_req(sys_rst_req), .sys_rst_full(sys_rst_full),
        .ext_rst_o(ext_rst_o), .ext_rst_oe(ext_rst_oe)
    );

    localparam logic [4:0] A_STAT = 5'h00, A_RLD = 5'h04, A_RST = 5'h08, A_CTL = 5'h0C, A_WID = 5'h18;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] width_model(input logic [31:0] cur, input logic [31:0] d);
        logic hi, pp;
        hi = cur[31]; pp = cur[30];
        case (d[31:24])
            8'hA5: hi = 1'b1;
            8'h5A: hi = 1'b0;
            8'hA8: pp = 1'b1;
            8'h8A: pp = 1'b0;
            default: ;
        endcase
        return {hi, pp, 18'b0, d[11:0]};
    endfunction

    // restart, then expect the pulse to start at step n+1 and last dur+1 steps
    task automatic run_fast(input int n, input int dur, input logic [5:0] ctl,
                            input logic hi, input logic pp);
        logic [31:0] v;
        logic inact;
        inact = !hi;
        wr(A_RLD, n);
        wr(A_CTL, {26'b0, ctl});
        wr(A_RST, 32'h4755);
        rd(A_STAT, v); chk("R3 restart loads reload", v, n);
        for (int j = 1; j <= n + dur + 2; j++) begin
            @(negedge clk);
            if (j == 1) begin rd(A_STAT, v); chk("R4 decrement per tick", v, n - 1); end
            if (j <= n) begin
                if (j == n) begin
                    chk("R11 inactive level before timeout", ext_rst_o, inact);
                    chk("R12 oe before timeout", ext_rst_oe, pp);
                    chk("R6 no irq before timeout", timeout_irq, 0);
                end
            end else if (j == n + 1) begin
                chk("R4/R7 pulse start at tick n+1", ext_rst_o, ctl[3] ? hi : inact);
                chk("R12 oe during pulse", ext_rst_oe, ctl[3] | pp);
                chk("R6 irq", timeout_irq, ctl[2]);
                chk("R6 sys reset req", sys_rst_req, ctl[1]);
                chk("R6 full chip", sys_rst_full, ctl[1] & ctl[5]);
            end else if (j == n + 2) begin
                chk("R6 irq one cycle", timeout_irq, 0);
                if (dur > 0) chk("R7 pulse held", ext_rst_o, ctl[3] ? hi : inact);
            end else if (j == n + dur + 1) begin
                chk("R7 pulse last tick", ext_rst_o, ctl[3] ? hi : inact);
            end else if (j == n + dur + 2) begin
                chk("R7 pulse ended", ext_rst_o, inact);
                chk("R12 oe after pulse", ext_rst_oe, pp);
            end
        end
        wr(A_CTL, 32'h0);
        repeat (dur + 4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m, d, s0;
        int len;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd(A_STAT, v); chk("R2 status reset", v, 32'h03EF1480);
        rd(A_RLD, v);  chk("R2 reload reset", v, 32'h03EF1480);
        rd(A_CTL, v);  chk("R2 control reset", v, 0);
        rd(A_WID, v);  chk("R2 width reset", v, 32'h000000FF);
        chk("R2 pin idle", ext_rst_o, 1);
        chk("R2 oe idle", ext_rst_oe, 0);

        // R1 decode
        rd(A_RST, v); chk("R1 restart reads 0", v, 0);
        rd(5'h14, v); chk("R1 unmapped reads 0", v, 0);
        rd(5'h05, v); chk("R1 misaligned reads 0", v, 0);
        wr(5'h06, 32'h1234);
        rd(A_RLD, v); chk("R1 misaligned write ignored", v, 32'h03EF1480);
        wr(A_CTL, 32'hFFFF_FFC0);
        rd(A_CTL, v); chk("R1 control keeps bits 5:0 only", v, 0);

        // R3 non-key restart ignored, R4 holds when stopped
        wr(A_RLD, 32'd50);
        rd(A_STAT, s0);
        for (int i = 0; i < 20; i++) begin
            d = $urandom;
            if (d == 32'h4755) d = 32'h4756;
            if (i == 0) d = 32'h0001_4755;
            wr(A_RST, d);
            rd(A_STAT, v); chk("R3 non-key restart ignored", v, s0);
        end
        repeat (5) @(negedge clk);
        rd(A_STAT, v); chk("R4 counter holds when stopped", v, s0);

        // R8 R9 R10 directed keys
        wr(A_WID, 32'hA500_0123); rd(A_WID, v); chk("R8 key sets level", v, 32'h8000_0123);
        wr(A_WID, 32'h80FF_FABC); rd(A_WID, v); chk("R9 plain write keeps bits, R10 dur", v, 32'h8000_0ABC);
        wr(A_WID, 32'hA800_0010); rd(A_WID, v); chk("R9 key sets drive", v, 32'hC000_0010);
        wr(A_WID, 32'h5A00_0011); rd(A_WID, v); chk("R8 key clears level", v, 32'h4000_0011);
        wr(A_WID, 32'h8A00_0012); rd(A_WID, v); chk("R9 key clears drive", v, 32'h0000_0012);

        // R8 R9 R10 random
        m = 32'h0000_0012;
        for (int i = 0; i < 150; i++) begin
            d = $urandom;
            case ($urandom_range(0, 5))
                0: d[31:24] = 8'hA5;
                1: d[31:24] = 8'h5A;
                2: d[31:24] = 8'hA8;
                3: d[31:24] = 8'h8A;
                default: ;
            endcase
            m = width_model(m, d);
            wr(A_WID, d);
            rd(A_WID, v); chk("R8/R9/R10 random width write", v, m);
        end

        // fast tick, open drain, active low
        wr(A_WID, 32'h5A00_0003); wr(A_WID, 32'h8A00_0003);
        run_fast(10, 3, 6'h2F, 1'b0, 1'b0);
        // ext disabled: irq only
        run_fast(6, 3, 6'h07, 1'b0, 1'b0);
        // irq/sys off, ext on, zero duration
        wr(A_WID, 32'h0000_0000);
        run_fast(5, 0, 6'h09, 1'b0, 1'b0);
        // active high, push-pull
        wr(A_WID, 32'hA500_0002); wr(A_WID, 32'hA800_0002);
        chk("R12 push-pull oe idle", ext_rst_oe, 1);
        chk("R11 active-high idle level", ext_rst_o, 0);
        run_fast(8, 2, 6'h0B, 1'b1, 1'b1);

        // R5 tick rates
        wr(A_RLD, 32'd100);
        wr(A_CTL, 32'h01);
        wr(A_RST, 32'h4755);
        rd(A_STAT, s0);
        repeat (DIV) @(negedge clk);
        rd(A_STAT, v); chk("R5 fast tick every clock", s0 - v, DIV);
        wr(A_CTL, 32'h11);
        rd(A_STAT, s0);
        repeat (DIV) @(negedge clk);
        rd(A_STAT, v); chk("R5 slow tick once per prescale", s0 - v, 1);
        wr(A_CTL, 32'h0);

        // R7 slow-tick pulse length: (dur+1)*DIV cycles, active low open drain
        wr(A_WID, 32'h5A00_0002); wr(A_WID, 32'h8A00_0002);
        wr(A_RLD, 32'd3);
        wr(A_CTL, 32'h19);
        wr(A_RST, 32'h4755);
        len = 0;
        for (int i = 0; i < 200 && ext_rst_o == 1'b1; i++) @(negedge clk);
        for (int i = 0; i < 200 && ext_rst_o == 1'b0; i++) begin
            len++;
            @(negedge clk);
        end
        chk("R7 slow pulse length", len, 3 * DIV);
        wr(A_CTL, 32'h0);
        repeat (20) @(negedge clk);
        chk("R11 idle after slow pulse", ext_rst_o, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule